// File: doc/BRIEF.md
# Clock Control Register Bank

This block holds the 32-bit control words of a clock control unit: the two PLL control words, the main clock control word, three clock-gating words, four peripheral divider words, three power-management words, a miscellaneous control word, and the other words of the map. They sit in a flat map of 28 words. A simple request port gives the host access. The port takes one request per cycle and answers exactly one cycle later with an acknowledge pulse, registered read data and an error flag. All 28 words are also driven out at once on a flat bus. The clock derivation logic downstream decodes that bus, and it uses the word order as its map.

A word is chosen by its byte offset divided by four, so word `i` sits at offset `4*i`. The legal window is offsets 0x00 to 0x6C. Only full-word, word-aligned accesses are legal. Any access outside the window, with a non-zero low address pair, or with a byte enable other than all ones is refused. A refused access raises the error flag, returns zero and leaves every word unchanged. Inside the window every bit can be written.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset these words hold their reset images: word 0 = 0x800B2C01, word 1 = 0x84042800, word 2 = 0xD0030000, word 3 = 0x028A0100, word 4 = 0x04008100, word 5 = 0x00000438, words 6 to 9 = 0x01010101, word 22 = 0x00A00000, words 23 and 24 = 0x0000A030, word 25 = 0x43000000.
- R2: After reset every word not listed in R1 reads zero.
- R3: A legal write (req=1, we=1, be=4'b1111, addr[1:0]=0, addr < 0x70) stores all 32 bits of wdata into word addr/4.
- R4: Every request gives ack=1 in the next cycle only. No ack appears in a cycle that does not follow a request.
- R5: A legal read returns word addr/4 on rdata in the ack cycle.
- R6: A read at addr >= 0x70 gives err=1 and rdata=0 in the ack cycle.
- R7: A write at addr >= 0x70 gives err=1 and changes no word.
- R8: A request with addr[1:0] != 0 gives err=1, returns rdata=0 and changes no word.
- R9: A request with be != 4'b1111 gives err=1, returns rdata=0 and changes no word.
- R10: A legal access gives err=0, and err is never 1 without ack.
- R11: The regsOut bus carries word i on bits [32*i+31 : 32*i] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset |
| be | input | 4 | Byte enables; only 4'b1111 is legal |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid with ack |
| ack | output | 1 | Response pulse, one cycle after req |
| err | output | 1 | Access refused, valid with ack |
| regsOut | output | 896 | All 28 words, word i at bits 32*i upward |

## Verification
The bench targets the window edge. Offset 0x6C must be accepted, and 0x70 and 0xFFC must be refused. A design that compares with the wrong bound either refuses the last word or lets a write alias onto word 0. Refused writes with a bad alignment or a partial byte enable are followed by a scan of the whole export bus. This catches a design that still stores part of the data. The bench reads all reset images back one by one and compares them against regsOut, so a swapped or mistyped reset constant shows up on both paths. It also checks that ack is a single-cycle pulse, which exposes a response that is held or late.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
    logic badStb;
  } accStrobes_t;

  function automatic logic [31:0] resetImage(input int unsigned idx);
    logic [31:0] v;
    case (idx)
      0:  v = 32'h800B_2C01;
      1:  v = 32'h8404_2800;
      2:  v = 32'hD003_0000;
      3:  v = 32'h028A_0100;
      4:  v = 32'h0400_8100;
      5:  v = 32'h0000_0438;
      6, 7, 8, 9: v = 32'h0101_0101;
      22: v = 32'h00A0_0000;
      23, 24: v = 32'h0000_A030;
      25: v = 32'h4300_0000;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 28,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output accStrobes_t       stb,
  output logic [IDX_W-1:0]  idx,
  output logic              ack,
  output logic              err
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);

  logic inWindow;
  logic aligned;
  logic fullWord;
  logic legal;

  always_comb begin
    inWindow   = addr < LIMIT;
    aligned    = addr[1:0] == 2'b00;
    fullWord   = be == 4'b1111;
    legal      = inWindow && aligned && fullWord;
    idx        = addr[IDX_W+1:2];
    stb.wrStb  = req && we && legal;
    stb.rdStb  = req && !we && legal;
    stb.badStb = req && !legal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      ack <= req;
      err <= stb.badStb;
    end
  end

endmodule

// File: rtl/clkctl_datapath.sv
module clkctl_datapath
  import clkctl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 28,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  accStrobes_t                stb,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] regsOut
);

  logic [DATA_W-1:0] words [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        words[g] <= DATA_W'(resetImage(g));
      end else if (stb.wrStb && (int'(idx) == g)) begin
        words[g] <= wdata;
      end
    end
    assign regsOut[g*DATA_W +: DATA_W] = words[g];
  end

  logic [DATA_W-1:0] readMux;

  always_comb begin
    readMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(idx) == i) readMux = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else begin
      rdata <= stb.rdStb ? readMux : '0;
    end
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 28,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       req,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [3:0]                 be,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       ack,
  output logic                       err,
  output logic [NUM_REGS*DATA_W-1:0] regsOut
);

  accStrobes_t      stb;
  logic [IDX_W-1:0] idx;

  clkctl_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .be(be),
    .stb(stb), .idx(idx), .ack(ack), .err(err)
  );

  clkctl_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .wdata(wdata),
    .rdata(rdata), .regsOut(regsOut)
  );

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 28,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       req,
  input logic                       we,
  input logic [ADDR_W-1:0]          addr,
  input logic [3:0]                 be,
  input logic [DATA_W-1:0]          wdata,
  input logic [DATA_W-1:0]          rdata,
  input logic                       ack,
  input logic                       err,
  input logic [NUM_REGS*DATA_W-1:0] regsOut
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);

  logic legalNow;
  assign legalNow = (addr < LIMIT) && (addr[1:0] == 2'b00) && (be == 4'b1111);

  logic [IDX_W-1:0]  lastIdx;
  logic [DATA_W-1:0] lastData;
  always_ff @(posedge clk) begin
    lastIdx  <= addr[IDX_W+1:2];
    lastData <= wdata;
  end

  logic [DATA_W-1:0] seenWord;
  always_comb begin
    seenWord = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(lastIdx) == i) seenWord = regsOut[i*DATA_W +: DATA_W];
    end
  end

  assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    req |=> ack);
  assert_no_stray_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    !req |=> !ack);
  assert_err_needs_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    err |-> ack);
  assert_legal_no_err_R10: assert property (@(posedge clk) disable iff (!rstN)
    req && legalNow |=> !err);
  assert_write_stores_R3: assert property (@(posedge clk) disable iff (!rstN)
    req && we && legalNow |=> seenWord == lastData);
  assert_far_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    req && !we && (addr >= LIMIT) |=> err && (rdata == '0));
  assert_far_write_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    req && we && (addr >= LIMIT) |=> err && $stable(regsOut));
  assert_misaligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    req && (addr[1:0] != 2'b00) |=> err && (rdata == '0) && $stable(regsOut));
  assert_partial_be_R9: assert property (@(posedge clk) disable iff (!rstN)
    req && (be != 4'b1111) |=> err && (rdata == '0) && $stable(regsOut));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .be(be),
  .wdata(wdata), .rdata(rdata), .ack(ack), .err(err), .regsOut(regsOut)
);

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb;

  localparam int NR = 28;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [11:0]   addr = '0;
  logic [3:0]    be = 4'hF;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ack;
  logic          err;
  logic [NR*32-1:0] regsOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] model [NR];

  always #10 clk = ~clk;

  clkctl_regbank u_dut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .ack(ack), .err(err), .regsOut(regsOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expReset(input int i);
    if (i == 0) return 32'h800B2C01;
    if (i == 1) return 32'h84042800;
    if (i == 2) return 32'hD0030000;
    if (i == 3) return 32'h028A0100;
    if (i == 4) return 32'h04008100;
    if (i == 5) return 32'h00000438;
    if (i >= 6 && i <= 9) return 32'h01010101;
    if (i == 22) return 32'h00A00000;
    if (i == 23 || i == 24) return 32'h0000A030;
    if (i == 25) return 32'h43000000;
    return 32'h0;
  endfunction

  // drive on negedge, sample on the following negedge (one posedge later)
  task automatic access(input logic w, input logic [11:0] a, input logic [3:0] b,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic ak, output logic er);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    rd = rdata; ak = ack; er = err;
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic checkExport(input string tag);
    for (int i = 0; i < NR; i++) chk(tag, regsOut[i*32 +: 32], model[i]);
  endtask

  task automatic testReset();
    logic [31:0] rd; logic ak, er;
    for (int i = 0; i < NR; i++) begin
      model[i] = expReset(i);
      access(1'b0, 12'(i*4), 4'hF, '0, rd, ak, er);
      chk((expReset(i) != 0) ? "R1 reset image" : "R2 reset zero", rd, model[i]);
      chk("R10 no err on legal read", {31'b0, er}, 32'h0);
    end
    checkExport("R11 export after reset");
  endtask

  task automatic testWriteRead();
    logic [31:0] rd; logic ak, er;
    int idxs[4] = '{0, 13, 27, 6};
    logic [31:0] pats[4] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0001, 32'h8000_0000};
    for (int k = 0; k < 4; k++) begin
      access(1'b1, 12'(idxs[k]*4), 4'hF, pats[k], rd, ak, er);
      model[idxs[k]] = pats[k];
      chk("R4 ack on write", {31'b0, ak}, 32'h1);
      chk("R10 no err on legal write", {31'b0, er}, 32'h0);
      chk("R3 stored word", regsOut[idxs[k]*32 +: 32], pats[k]);
      access(1'b0, 12'(idxs[k]*4), 4'hF, '0, rd, ak, er);
      chk("R5 readback", rd, pats[k]);
    end
    checkExport("R11 export after writes");
  endtask

  task automatic testOutOfRange();
    logic [31:0] rd; logic ak, er;
    access(1'b0, 12'h070, 4'hF, '0, rd, ak, er);
    chk("R6 far read err", {31'b0, er}, 32'h1);
    chk("R6 far read data", rd, 32'h0);
    access(1'b0, 12'hFFC, 4'hF, '0, rd, ak, er);
    chk("R6 top read err", {31'b0, er}, 32'h1);
    access(1'b1, 12'h070, 4'hF, 32'hDEAD_BEEF, rd, ak, er);
    chk("R7 far write err", {31'b0, er}, 32'h1);
    checkExport("R7 far write no change");
    access(1'b1, 12'h06C, 4'hF, 32'h1234_5678, rd, ak, er);
    model[27] = 32'h1234_5678;
    chk("R10 last word legal", {31'b0, er}, 32'h0);
    chk("R3 last word stored", regsOut[27*32 +: 32], 32'h1234_5678);
  endtask

  task automatic testUnaligned();
    logic [31:0] rd; logic ak, er;
    access(1'b1, 12'h002, 4'hF, 32'hCAFE_F00D, rd, ak, er);
    chk("R8 misaligned write err", {31'b0, er}, 32'h1);
    checkExport("R8 misaligned no change");
    access(1'b0, 12'h009, 4'hF, '0, rd, ak, er);
    chk("R8 misaligned read err", {31'b0, er}, 32'h1);
    chk("R8 misaligned read data", rd, 32'h0);
  endtask

  task automatic testPartialBe();
    logic [31:0] rd; logic ak, er;
    access(1'b1, 12'h010, 4'b0111, 32'h7777_7777, rd, ak, er);
    chk("R9 partial write err", {31'b0, er}, 32'h1);
    checkExport("R9 partial no change");
    access(1'b0, 12'h000, 4'b0001, '0, rd, ak, er);
    chk("R9 partial read err", {31'b0, er}, 32'h1);
    chk("R9 partial read data", rd, 32'h0);
  endtask

  task automatic testIdle();
    logic [31:0] rd; logic ak, er;
    access(1'b0, 12'h008, 4'hF, '0, rd, ak, er);
    chk("R4 ack present", {31'b0, ak}, 32'h1);
    @(negedge clk);
    chk("R4 ack is single pulse", {31'b0, ack}, 32'h0);
    chk("R10 no err when idle", {31'b0, err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 no ack after reset", {31'b0, ack}, 32'h0);
    testReset();
    testWriteRead();
    testOutOfRange();
    testUnaligned();
    testPartialBe();
    testIdle();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule